// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block takes a control word that a host shifts in over a three-wire serial bus (data, clock, enable) and turns it into parallel settings for a frequency synthesizer: a 14-bit loop divide value, a band-select bit that picks the low-band (AM) or high-band (FM) oscillator input, a two-bit choice among four reference rates, and two general-purpose output bits that drive external pins. Several devices, display drivers for example, may share the same three wires. The two bits at the head of every word are a device address, and a word takes effect only when that address matches this receiver's own.

All three bus lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer before its edges are detected. While enable is high, the receiver samples one data bit on each rising edge of the bus clock, most significant bit first, and counts the bits. The falling edge of enable closes the word. At that point the parallel registers are updated only if the bit count equals the full frame length and the address matches. Any other word leaves every output as it was.

Top module: `scw_receiver`

## Requirements
- R1: After reset, div_n is 0, band_fm is 0 (low band), ref_sel is 0 and gpo_out is 0.
- R2: A frame of exactly 21 bits is sent MSB first. Its bits, first to last, are the address (2 bits), then div_n (14 bits, MSB first), then band_fm, then ref_sel (MSB first), then gpo_out (MSB first). When the address equals DEV_ADDR (default 2'b10), all four outputs take these values.
- R3: A 21-bit frame whose address differs from DEV_ADDR leaves all outputs unchanged.
- R4: A frame of fewer than 21 bits leaves all outputs unchanged.
- R5: A frame of more than 21 bits leaves all outputs unchanged, even when its last 21 bits form a valid word.
- R6: Bus clock edges while enable is low shift nothing and change no output.
- R7: Outputs hold their values while enable is high. They change on the third system clock edge after enable falls, and at no other time.
- R8: A rising edge on enable starts a new frame. A later valid frame fully overwrites the values of an earlier one, including the all-ones and all-zeros field extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bus clock (asynchronous) |
| bus_data | input | 1 | Serial bus data, MSB first |
| bus_en | input | 1 | Serial bus enable, high for the length of a frame |
| div_n | output | 14 | Loop divide value |
| band_fm | output | 1 | 1 selects the high-band input, 0 the low-band input |
| ref_sel | output | 2 | Reference rate select, one of four |
| gpo_out | output | 2 | General-purpose output bits |

## Verification
If the bit counter or the shift register held a wrong value, a frame would be accepted or rejected wrongly. The error would then reach the outputs three system clocks after enable falls, as a wrong set of fields or as a stale value that should have changed. A load that fires outside an enable fall shows up as outputs moving while enable is high. The directed frames therefore check the outputs both just before and just after that third edge. They also cover counts of one bit less and one bit more than the frame length, and fields at their extreme values.

// File: rtl/scw_pkg.sv
package scw_pkg;
   localparam int SCW_ADDR_W = 2;
   localparam int SCW_DIV_W  = 14;
   localparam int SCW_REF_W  = 2;
   localparam int SCW_GPO_W  = 2;
   typedef enum logic {BAND_LOW = 1'b0, BAND_HIGH = 1'b1} scw_band_e;
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scw_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("scw_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= d_in;
         for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
   parameter int FRAME_W = 21,
   parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_lvl,
   input  logic               en_rise,
   input  logic               clk_rise,
   input  logic               din,
   output logic [FRAME_W-1:0] word,
   output logic [CNT_W-1:0]   cnt
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         cnt  <= '0;
      end else if (en_rise) begin
         cnt <= '0;
      end else if (en_lvl && clk_rise) begin
         word <= {word[FRAME_W-2:0], din};
         if (cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/scw_decode.sv
module scw_decode
   import scw_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int DIV_W    = 14,
   parameter int REF_W    = 2,
   parameter int GPO_W    = 2,
   parameter logic [ADDR_W-1:0] DEV_ADDR = '0,
   parameter int FRAME_W  = ADDR_W + DIV_W + 1 + REF_W + GPO_W,
   parameter int CNT_W    = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_fall,
   input  logic [FRAME_W-1:0] word,
   input  logic [CNT_W-1:0]   cnt,
   output logic               load,
   output logic [DIV_W-1:0]   div_n,
   output scw_band_e          band,
   output logic [REF_W-1:0]   ref_sel,
   output logic [GPO_W-1:0]   gpo
);
   localparam int GPO_LSB  = 0;
   localparam int REF_LSB  = GPO_LSB + GPO_W;
   localparam int BAND_POS = REF_LSB + REF_W;
   localparam int DIV_LSB  = BAND_POS + 1;
   localparam int ADDR_LSB = DIV_LSB + DIV_W;

   logic addr_hit;
   logic len_ok;

   assign addr_hit = (word[ADDR_LSB +: ADDR_W] == DEV_ADDR);
   assign len_ok   = (cnt == CNT_W'(FRAME_W));
   assign load     = en_fall && len_ok && addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_n   <= '0;
         band    <= BAND_LOW;
         ref_sel <= '0;
         gpo     <= '0;
      end else if (load) begin
         div_n   <= word[DIV_LSB +: DIV_W];
         band    <= scw_band_e'(word[BAND_POS]);
         ref_sel <= word[REF_LSB +: REF_W];
         gpo     <= word[GPO_LSB +: GPO_W];
      end
   end
endmodule

// File: rtl/scw_receiver.sv
module scw_receiver
   import scw_pkg::*;
#(
   parameter int ADDR_W      = SCW_ADDR_W,
   parameter int DIV_W       = SCW_DIV_W,
   parameter int REF_W       = SCW_REF_W,
   parameter int GPO_W       = SCW_GPO_W,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 2'b10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_clk,
   input  logic             bus_data,
   input  logic             bus_en,
   output logic [DIV_W-1:0] div_n,
   output logic             band_fm,
   output logic [REF_W-1:0] ref_sel,
   output logic [GPO_W-1:0] gpo_out
);
   localparam int FRAME_W = ADDR_W + DIV_W + 1 + REF_W + GPO_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   generate
      if (ADDR_W < 1 || DIV_W < 1 || REF_W < 1 || GPO_W < 1) begin : g_bad_fields
         $error("scw_receiver: every field width must be positive");
      end
   endgenerate

   logic [2:0]         sync_q;
   logic               s_clk, s_dat, s_en;
   logic               p_clk, p_en;
   logic               clk_rise, en_rise, en_fall;
   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   cnt;
   logic               load;
   scw_band_e          band;

   scw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({bus_en, bus_data, bus_clk}),
      .q_out (sync_q)
   );

   assign s_clk = sync_q[0];
   assign s_dat = sync_q[1];
   assign s_en  = sync_q[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_clk <= 1'b0;
         p_en  <= 1'b0;
      end else begin
         p_clk <= s_clk;
         p_en  <= s_en;
      end
   end

   assign clk_rise = s_clk & ~p_clk;
   assign en_rise  = s_en & ~p_en;
   assign en_fall  = ~s_en & p_en;

   scw_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_lvl   (s_en),
      .en_rise  (en_rise),
      .clk_rise (clk_rise),
      .din      (s_dat),
      .word     (word),
      .cnt      (cnt)
   );

   scw_decode #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .REF_W(REF_W), .GPO_W(GPO_W),
      .DEV_ADDR(DEV_ADDR), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
   ) dec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_fall (en_fall),
      .word    (word),
      .cnt     (cnt),
      .load    (load),
      .div_n   (div_n),
      .band    (band),
      .ref_sel (ref_sel),
      .gpo     (gpo_out)
   );

   assign band_fm = (band == BAND_HIGH);
endmodule

// File: rtl/scw_receiver_chk.sv
module scw_receiver_chk #(
   parameter int FRAME_W = 21,
   parameter int CNT_W   = 5,
   parameter int DIV_W   = 14,
   parameter int OUT_W   = 19
) (
   input logic               clk,
   input logic               rst_n,
   input logic               load,
   input logic               s_en,
   input logic               en_fall,
   input logic [CNT_W-1:0]   cnt,
   input logic [FRAME_W-1:0] word,
   input logic [DIV_W-1:0]   div_n,
   input logic [OUT_W-1:0]   outs
);
   // R7
   hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(outs));

   // R7
   load_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (en_fall && !s_en));

   // R4
   load_full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (cnt == CNT_W'(FRAME_W)));

   // R5
   count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_W + 1));

   // R2
   div_from_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (div_n == $past(word[FRAME_W-3 -: DIV_W])));

   // R6
   no_count_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_en && !$rose(s_en)) |=> $stable(cnt));
endmodule

bind scw_receiver scw_receiver_chk #(
   .FRAME_W(FRAME_W), .CNT_W(CNT_W), .DIV_W(DIV_W),
   .OUT_W(DIV_W + 1 + REF_W + GPO_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .load    (load),
   .s_en    (s_en),
   .en_fall (en_fall),
   .cnt     (cnt),
   .word    (word),
   .div_n   (div_n),
   .outs    ({div_n, band_fm, ref_sel, gpo_out})
);

// File: tb/scw_receiver_tb_top.sv
module scw_receiver_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_clk = 1'b0;
   logic bus_data = 1'b0;
   logic bus_en = 1'b0;
   logic [13:0] div_n;
   logic        band_fm;
   logic [1:0]  ref_sel;
   logic [1:0]  gpo_out;

   int total = 0;
   int bad = 0;
   logic [18:0] exp_out;

   always #2 clk = ~clk;

   scw_receiver dut_i (
      .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
      .bus_en(bus_en), .div_n(div_n), .band_fm(band_fm),
      .ref_sel(ref_sel), .gpo_out(gpo_out)
   );

   function automatic logic [31:0] mk(input logic [1:0] a, input logic [13:0] n,
                                      input logic b, input logic [1:0] r,
                                      input logic [1:0] g);
      return {11'd0, a, n, b, r, g};
   endfunction

   task automatic check(input string req, input logic [18:0] exp);
      logic [18:0] act;
      act = {div_n, band_fm, ref_sel, gpo_out};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put_bits(input logic [31:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         bus_data = w[i];
         wait_clks(4);
         bus_clk = 1'b1;
         wait_clks(4);
         bus_clk = 1'b0;
         wait_clks(4);
      end
   endtask

   task automatic send(input logic [31:0] w, input int nbits);
      @(negedge clk);
      bus_en = 1'b1;
      wait_clks(6);
      put_bits(w, nbits);
      bus_en = 1'b0;
      wait_clks(8);
   endtask

   task automatic t_reset();
      check("R1 reset", 19'd0);
   endtask

   task automatic t_good();
      send(mk(2'b10, 14'h2A5C, 1'b1, 2'b10, 2'b01), 21);
      exp_out = {14'h2A5C, 1'b1, 2'b10, 2'b01};
      check("R2 valid frame", exp_out);
   endtask

   task automatic t_timing();
      logic [18:0] nxt;
      nxt = {14'h0155, 1'b0, 2'b01, 2'b10};
      @(negedge clk);
      bus_en = 1'b1;
      wait_clks(6);
      put_bits(mk(2'b10, 14'h0155, 1'b0, 2'b01, 2'b10), 21);
      wait_clks(6);
      check("R7 held while enable high", exp_out);
      bus_en = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check("R7 unchanged after two edges", exp_out);
      @(posedge clk); #1;
      check("R7 updated on third edge", nxt);
      exp_out = nxt;
      wait_clks(4);
   endtask

   task automatic t_wrong_addr();
      send(mk(2'b01, 14'h1111, 1'b1, 2'b11, 2'b11), 21);
      check("R3 address 01", exp_out);
      send(mk(2'b11, 14'h3333, 1'b1, 2'b11, 2'b11), 21);
      check("R3 address 11", exp_out);
   endtask

   task automatic t_short();
      send(mk(2'b10, 14'h0FFF, 1'b1, 2'b11, 2'b11) >> 1, 20);
      check("R4 twenty bits", exp_out);
   endtask

   task automatic t_long();
      send(mk(2'b10, 14'h1ABC, 1'b1, 2'b11, 2'b00), 22);
      check("R5 twenty-two bits", exp_out);
   endtask

   task automatic t_idle_clk();
      logic [31:0] w;
      w = mk(2'b10, 14'h3FFF, 1'b1, 2'b11, 2'b11);
      put_bits(w, 21);
      wait_clks(8);
      check("R6 edges with enable low", exp_out);
   endtask

   task automatic t_overwrite();
      send(mk(2'b10, 14'h3FFF, 1'b1, 2'b11, 2'b11), 21);
      exp_out = {14'h3FFF, 1'b1, 2'b11, 2'b11};
      check("R8 all ones", exp_out);
      send(mk(2'b10, 14'h0000, 1'b0, 2'b00, 2'b00), 21);
      exp_out = 19'd0;
      check("R8 all zeros", exp_out);
      send(mk(2'b10, 14'h2001, 1'b0, 2'b01, 2'b10), 21);
      exp_out = {14'h2001, 1'b0, 2'b01, 2'b10};
      check("R8 end bits", exp_out);
   endtask

   task automatic t_after_reject();
      send(mk(2'b10, 14'h0AAA, 1'b1, 2'b00, 2'b01) >> 2, 19);
      send(mk(2'b10, 14'h1234, 1'b1, 2'b00, 2'b01), 21);
      exp_out = {14'h1234, 1'b1, 2'b00, 2'b01};
      check("R8 new frame after short one", exp_out);
   endtask

   initial begin
      exp_out = 19'd0;
      wait_clks(4);
      t_reset();
      rst_n = 1'b1;
      wait_clks(4);
      t_reset();
      t_good();
      t_timing();
      t_wrong_addr();
      t_short();
      t_long();
      t_idle_clk();
      t_overwrite();
      t_after_reject();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule